// File: doc/BRIEF.md
# Bi-phase Backward Frame Transmitter

This block sends one answer frame on a two-wire lighting control line. The line carries one serial output, and bits are sent with bi-phase coding. Software sets up a transfer in three steps. It places an 8-bit answer on the data input and chooses the bit rate with a divider value. It then issues a control write in which the transmit-direction bit and the arm bit are both set. The block loads a start bit of value 1 in front of the data byte. It shifts the nine bits out most significant first, one half-bit period for each phase, and follows them with two stop bits that hold the line high.

After the last stop bit, the block raises a completion flag. It stays blocked, with the line high, until software arms it again. An arm write that has the direction bit clear clears the flag and returns the block to receive mode. No frame is sent in that case. An arm write that has the direction bit set starts a new frame. The half-bit period is (N+1)*16 system clocks, where N is the divider value.

Top module: `dali_bwd_tx`

## Requirements
- R1: After reset the line output is high and the completion flag is low.
- R2: A frame starts only on a control write (ctl_we=1) in which both ctl_arm=1 and ctl_dir=1. A write with ctl_arm=0, or one with ctl_dir=0, sends nothing.
- R3: A frame begins with nine bi-phase bits: a start bit of value 1, then tx_data bits 7 down to 0. A 1 is sent low for one half-bit and then high for one half-bit. A 0 is sent high and then low.
- R4: After the ninth bit, the line stays high for four half-bit periods, which form the two stop bits. The line is also high whenever no frame is in progress.
- R5: The completion flag rises exactly 22 half-bit periods after the clock edge that accepted the start write. It is low before that point.
- R6: While the flag is set and no arm write occurs, no frame is sent, the flag stays high, and changes on tx_data have no effect on the line.
- R7: Any arm write clears the flag. When ctl_dir=0 the block goes to receive mode and the line stays high.
- R8: Control writes that arrive while a frame is being sent are ignored, and the frame goes on unchanged.
- R9: One half-bit period lasts (div_n+1)*16 clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_n | input | DIV_W | Divider value N; half-bit period = (N+1)*16 clocks |
| tx_data | input | DATA_W | Answer byte to send |
| ctl_we | input | 1 | Control write strobe |
| ctl_dir | input | 1 | Direction bit of the write: 1 = transmit, 0 = receive |
| ctl_arm | input | 1 | Arm bit of the write |
| line_o | output | 1 | Serial line, idle high |
| done_flag_o | output | 1 | Completion flag, set at end of frame |

## Verification
The assertions are checked on every cycle. They check the following:
- A frame starts only after a write with both the arm and direction bits set.
- The line changes only on a half-bit tick.
- The stop region is high.
- The flag rises only at the end of the final half-bit.
- The flag falls only on an arm write.
- The flag holds, with no frame, while no arm write arrives.

The bench scenarios cover what a cycle-local property cannot show. These are the exact bit pattern against the data byte, the length of the half-bit period for several divider values, the ignoring of writes in the middle of a frame, and the absence of any line activity over long blocked and receive-mode windows.

// File: rtl/dali_bwd_tx.sv
module dali_bwd_tx #(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_n,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              ctl_we,
  input  logic              ctl_dir,
  input  logic              ctl_arm,
  output logic              line_o,
  output logic              done_flag_o
);
  localparam int CW      = DIV_W + 4;
  localparam int CODED   = 2 * (DATA_W + 1);
  localparam int HALVES  = CODED + 4;
  localparam int HW      = $clog2(HALVES);

  typedef enum logic [1:0] {S_RX, S_TX, S_HOLD} st_t;

  st_t             st;
  logic [CW-1:0]   cnt;
  logic [HW-1:0]   half_idx;
  logic [DATA_W:0] sh;

  logic busy, tick, arm_wr, in_coded;

  assign busy     = (st == S_TX);
  assign tick     = busy && (cnt == {div_n, 4'hF});
  assign arm_wr   = ctl_we && ctl_arm;
  assign in_coded = (half_idx < HW'(CODED));
  assign line_o   = (busy && in_coded) ? (sh[DATA_W] ^ ~half_idx[0]) : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_RX;
      cnt         <= '0;
      half_idx    <= '0;
      sh          <= '0;
      done_flag_o <= 1'b0;
    end else if (busy) begin
      if (tick) begin
        cnt <= '0;
        if (half_idx == HW'(HALVES - 1)) begin
          st          <= S_HOLD;
          done_flag_o <= 1'b1;
        end else begin
          half_idx <= half_idx + 1'b1;
          if (half_idx[0] && in_coded)
            sh <= {sh[DATA_W-1:0], 1'b0};
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (arm_wr) begin
      done_flag_o <= 1'b0;
      if (ctl_dir) begin
        st       <= S_TX;
        sh       <= {1'b1, tx_data};
        cnt      <= '0;
        half_idx <= '0;
      end else begin
        st <= S_RX;
      end
    end
  end
endmodule

module dali_bwd_tx_chk #(
  parameter int HW     = 5,
  parameter int HALVES = 22,
  parameter int CODED  = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_we,
  input logic          ctl_dir,
  input logic          ctl_arm,
  input logic          line_o,
  input logic          done_flag_o,
  input logic          busy,
  input logic          tick,
  input logic [HW-1:0] half_idx
);
  p_start_needs_both_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ctl_we && ctl_arm && ctl_dir));

  p_line_moves_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(tick)) |-> $stable(line_o));

  p_stop_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && half_idx >= HW'(CODED)) |-> line_o);

  p_flag_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag_o) |-> ($past(busy) && $past(tick) && $past(half_idx) == HW'(HALVES - 1)));

  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_flag_o) |-> $past(ctl_we && ctl_arm));

  p_hold_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag_o && !(ctl_we && ctl_arm)) |=> (done_flag_o && !busy && line_o));
endmodule

bind dali_bwd_tx dali_bwd_tx_chk #(.HW(HW), .HALVES(HALVES), .CODED(CODED)) i_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_dir(ctl_dir), .ctl_arm(ctl_arm),
  .line_o(line_o), .done_flag_o(done_flag_o), .busy(busy), .tick(tick),
  .half_idx(half_idx)
);

// File: tb/test_dali_bwd_tx.sv
module test_dali_bwd_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div_n = 8'd0;
  logic [7:0] tx_data = 8'h00;
  logic       ctl_we = 1'b0, ctl_dir = 1'b0, ctl_arm = 1'b0;
  logic       line_o, done_flag_o;

  int n_chk = 0, n_bad = 0, low_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dali_bwd_tx i_dali_bwd_tx (
    .clk(clk), .rst_n(rst_n), .div_n(div_n), .tx_data(tx_data),
    .ctl_we(ctl_we), .ctl_dir(ctl_dir), .ctl_arm(ctl_arm),
    .line_o(line_o), .done_flag_o(done_flag_o)
  );

  always @(negedge clk) if (!line_o) low_cnt++;

  // {divider N, data byte}
  localparam logic [15:0] VEC [6] = '{16'h00A5, 16'h0000, 16'h01FF, 16'h0280, 16'h0301, 16'h005C};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [21:0] exp_frame(input logic [7:0] d);
    logic [21:0] f;
    for (int h = 0; h < 22; h++) begin
      logic b;
      if (h >= 18) f[h] = 1'b1;
      else begin
        b = (h < 2) ? 1'b1 : d[7 - (h / 2 - 1)];
        f[h] = (h % 2 == 0) ? ~b : b;
      end
    end
    return f;
  endfunction

  task automatic ctl_write(input logic dir, input logic arm);
    @(negedge clk);
    ctl_we = 1'b1; ctl_dir = dir; ctl_arm = arm;
    @(negedge clk);
    ctl_we = 1'b0; ctl_arm = 1'b0; ctl_dir = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] d, input logic [7:0] n, input bit poke);
    int p;
    logic [21:0] got;
    div_n = n;
    tx_data = d;
    p = (int'(n) + 1) * 16;
    ctl_write(1'b1, 1'b1);
    check("R7 flag cleared by arm", done_flag_o, 1'b0);
    repeat (p / 2) @(negedge clk);
    for (int h = 0; h < 22; h++) begin
      got[h] = line_o;
      if (h < 21) begin
        if (poke && h == 5) begin
          tx_data = ~d;
          ctl_we = 1'b1; ctl_dir = 1'b1; ctl_arm = 1'b1;
          @(negedge clk);
          ctl_we = 1'b0; ctl_arm = 1'b0; ctl_dir = 1'b0;
          repeat (p - 1) @(negedge clk);
        end else begin
          repeat (p) @(negedge clk);
        end
      end
    end
    if (poke) check("R8 mid-frame write ignored", got, exp_frame(d));
    else      check("R3 bi-phase frame", got, exp_frame(d));
    check("R4 stop bits high", got[21:18], 4'hF);
    repeat (p / 2 - 1) @(negedge clk);
    check("R5 flag low before end", done_flag_o, 1'b0);
    @(negedge clk);
    check("R9 flag at 22 half-bits", done_flag_o, 1'b1);
    check("R4 line idle high", line_o, 1'b1);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 line after reset", line_o, 1'b1);
    check("R1 flag after reset", done_flag_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    tx_data = 8'h00;
    low_cnt = 0;
    ctl_write(1'b1, 1'b0);
    repeat (100) @(negedge clk);
    check("R2 direction alone sends nothing", low_cnt, 0);
    ctl_write(1'b0, 1'b1);
    repeat (100) @(negedge clk);
    check("R2 arm without direction sends nothing", low_cnt, 0);
    check("R7 receive mode flag low", done_flag_o, 1'b0);

    for (int i = 0; i < 6; i++) send_frame(VEC[i][7:0], VEC[i][15:8], 1'b0);

    low_cnt = 0;
    for (int k = 0; k < 8; k++) begin
      tx_data = 8'h11 * k[7:0];
      repeat (40) @(negedge clk);
    end
    check("R6 blocked: no line activity", low_cnt, 0);
    check("R6 blocked: flag held", done_flag_o, 1'b1);

    low_cnt = 0;
    ctl_write(1'b0, 1'b1);
    check("R7 receive arm clears flag", done_flag_o, 1'b0);
    repeat (200) @(negedge clk);
    check("R7 receive arm sends nothing", low_cnt, 0);

    send_frame(8'h3C, 8'd1, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule